// File: doc/BRIEF.md
# Glitch-Free Programmable Clock Post-Divider

This block sits behind a fast oscillator clock and produces a slower clock at one of five power-of-two ratios (2, 4, 8, 16 or 32). A 3-bit select code picks the ratio. The result leaves the block as a true/complement pair: two registered outputs that are always exact inverses of each other. The duty cycle is 50 percent, with equal high and low phases of half the ratio in fast-clock cycles.

Both the output enable and the ratio select are applied only at safe points, so the output never carries a shortened pulse:
- A new select code is captured when the divided clock falls, so the following low phase and high phase both use the new ratio.
- The enable is consulted only while the divided clock is low.
  - Dropping the enable lets the running high phase finish, then lets the low phase finish, then parks the pair with the true output low and the complement high.
  - Raising the enable from the parked state starts a full-length high phase.
- A select code that names no ratio stops the output in the same parked state.

The enable pin is meant to be tied or pulled high by the integrator when the output is always wanted. The reset is synchronous and active high.

Top module: `clk_post_divider`

## Requirements
- R1: Select code value k in 1..5 (binary 001, 010, 011, 100, 101) divides the fast clock by 2^k, so one output period lasts 2^k fast-clock cycles.
- R2: Select codes 000, 110 and 111 name no ratio; when one is present at a capture point, the output parks (true low, complement high) and stays parked while the code remains invalid.
- R3: While running, every high phase and every low phase lasts exactly 2^(k-1) fast-clock cycles (50 percent duty), including the first high phase after start.
- R4: The enable is only sampled at the end of a low phase (or while parked); a change of enable during a high phase or in the middle of a low phase neither cuts nor stretches that phase.
- R5: When the enable rises while parked with a valid code, the true output goes high at the next fast-clock edge and stays high for a full half period.
- R6: A new select code is captured only when the divided clock falls; a change in the middle of a high or low phase first affects the low phase that follows the next falling edge.
- R7: With the enable low at the end of a low phase, the pair parks with the true output at 0 and the complement at 1 and stays there while the enable stays low.
- R8: The complement output equals the inverse of the true output in every cycle.
- R9: While reset is high at a clock edge, the true output becomes 0 and the complement 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| div_code | input | 3 | Ratio select; value k in 1..5 means divide by 2^k, other values park the output |
| out_en | input | 1 | Output enable, high to run; applied only while the divided clock is low |
| clk_out | output | 1 | Divided clock, true phase |
| clk_out_n | output | 1 | Divided clock, complement phase |

## Verification
A corrupted phase counter or phase state shows at the ports within one half period as a high or low run of the wrong length, so the bench measures every run length in fast-clock cycles against 2^(k-1) for all eight codes. A wrongly held ratio appears as a mismatch on the first phase after the next falling edge, and an enable applied at the wrong moment appears as a high phase cut short or a missing full phase within one period. A mismatch between the two outputs is visible in the same cycle.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    // Phase of the divided clock as tracked by the sequencer.
    typedef enum logic [1:0] {
        PH_PARK = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    // Width of the half-period counter for a largest ratio of 2**max_log.
    function automatic int span_bits(input int max_log);
        return (max_log > 1) ? (max_log - 1) : 1;
    endfunction

    // Terminal count for a half period at ratio 2**log_ratio.
    function automatic int half_minus_one(input int log_ratio);
        return (1 << (log_ratio - 1)) - 1;
    endfunction

endpackage

// File: rtl/pdiv_decode.sv
module pdiv_decode #(
    parameter int CODE_W  = 3,
    parameter int MAX_LOG = 5,
    parameter int SPAN_W  = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic              code_ok,
    output logic [SPAN_W-1:0] code_span
);
    import pdiv_pkg::*;

    logic [MAX_LOG-1:0] hit;

    // One comparator per legal ratio code.
    for (genvar g = 1; g <= MAX_LOG; g++) begin : g_hit
        assign hit[g-1] = (code == CODE_W'(g));
    end

    always_comb begin
        code_ok   = |hit;
        code_span = '0;
        for (int i = 0; i < MAX_LOG; i++) begin
            if (hit[i]) code_span = SPAN_W'(half_minus_one(i + 1));
        end
    end

endmodule

// File: rtl/pdiv_span_timer.sv
module pdiv_span_timer #(
    parameter int SPAN_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SPAN_W-1:0] load_val,
    output logic              done
);
    logic [SPAN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/pdiv_sequencer.sv
module pdiv_sequencer #(
    parameter int SPAN_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              code_ok,
    input  logic [SPAN_W-1:0] code_span,
    input  logic              done,
    output logic              load,
    output logic [SPAN_W-1:0] load_val,
    output logic              q_next,
    output pdiv_pkg::phase_e  phase
);
    import pdiv_pkg::*;

    phase_e            phase_q, phase_d;
    logic [SPAN_W-1:0] held_q, held_d;

    always_comb begin
        phase_d  = phase_q;
        held_d   = held_q;
        load     = 1'b0;
        load_val = held_q;
        unique case (phase_q)
            PH_PARK: begin
                if (en && code_ok) begin
                    phase_d  = PH_HIGH;
                    held_d   = code_span;
                    load     = 1'b1;
                    load_val = code_span;
                end
            end
            PH_HIGH: begin
                if (done) begin
                    if (code_ok) begin
                        phase_d  = PH_LOW;
                        held_d   = code_span;
                        load     = 1'b1;
                        load_val = code_span;
                    end else begin
                        phase_d  = PH_PARK;
                    end
                end
            end
            PH_LOW: begin
                if (done) begin
                    if (en) begin
                        phase_d  = PH_HIGH;
                        load     = 1'b1;
                        load_val = held_q;
                    end else begin
                        phase_d  = PH_PARK;
                    end
                end
            end
            default: phase_d = PH_PARK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_PARK;
            held_q  <= '0;
        end else begin
            phase_q <= phase_d;
            held_q  <= held_d;
        end
    end

    assign q_next = (phase_d == PH_HIGH);
    assign phase  = phase_q;

    // R3: a low phase is never cut short by any input
    a_r3_low_whole: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOW && !done) |=> (phase_q == PH_LOW));

    // R4: a high phase is never cut short by the enable or the code
    a_r4_high_whole: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HIGH && !done) |=> (phase_q == PH_HIGH));

    // R2: an invalid code at the falling point parks the output
    a_r2_invalid_parks: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HIGH && done && !code_ok) |=> (phase_q == PH_PARK));

    // R5: enabling from park starts a high phase at once
    a_r5_start_high: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PARK && en && code_ok) |=> (phase_q == PH_HIGH));

    // R6: the held ratio stays put during a low phase
    a_r6_ratio_held: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOW) |=> $stable(held_q));

endmodule

// File: rtl/pdiv_out_pair.sv
module pdiv_out_pair (
    input  logic clk,
    input  logic rst,
    input  logic q_next,
    output logic q,
    output logic qn
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q  <= 1'b0;
            qn <= 1'b1;
        end else begin
            q  <= q_next;
            qn <= ~q_next;
        end
    end

    // R8: the two outputs never overlap
    a_r8_complement: assert property (@(posedge clk) disable iff (rst)
        (qn == ~q));

    // R9: reset parks the pair
    a_r9_reset_park: assert property (@(posedge clk)
        rst |=> (!q && qn));

endmodule

// File: rtl/clk_post_divider.sv
module clk_post_divider #(
    parameter int CODE_W  = 3,
    parameter int MAX_LOG = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] div_code,
    input  logic              out_en,
    output logic              clk_out,
    output logic              clk_out_n
);
    import pdiv_pkg::*;

    localparam int SPAN_W = span_bits(MAX_LOG);

    logic              code_ok;
    logic [SPAN_W-1:0] code_span;
    logic              load;
    logic [SPAN_W-1:0] load_val;
    logic              done;
    logic              q_next;
    phase_e            phase;

    pdiv_decode #(.CODE_W(CODE_W), .MAX_LOG(MAX_LOG), .SPAN_W(SPAN_W)) u_decode (
        .code      (div_code),
        .code_ok   (code_ok),
        .code_span (code_span)
    );

    pdiv_span_timer #(.SPAN_W(SPAN_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .done     (done)
    );

    pdiv_sequencer #(.SPAN_W(SPAN_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (out_en),
        .code_ok   (code_ok),
        .code_span (code_span),
        .done      (done),
        .load      (load),
        .load_val  (load_val),
        .q_next    (q_next),
        .phase     (phase)
    );

    pdiv_out_pair u_out (
        .clk (clk),
        .rst (rst),
        .q_next (q_next),
        .q   (clk_out),
        .qn  (clk_out_n)
    );

    // R7: enable low at the end of a low phase parks the pair
    a_r7_disable_parks: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOW && done && !out_en) |=> (!clk_out && clk_out_n));

    // R7: a parked pair stays parked while the enable is low
    a_r7_stay_parked: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PARK && !out_en) |=> (!clk_out && clk_out_n));

endmodule

// File: tb/sim_clk_post_divider.sv
module sim_clk_post_divider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] div_code = 3'd0;
    logic       out_en = 1'b0;
    logic       clk_out;
    logic       clk_out_n;

    int n_chk = 0;
    int n_bad = 0;
    int comp_bad = 0;
    bit mon_on = 1'b0;
    bit wd_hit = 1'b0;

    always #5 clk = ~clk;

    clk_post_divider u0 (
        .clk       (clk),
        .rst       (rst),
        .div_code  (div_code),
        .out_en    (out_en),
        .clk_out   (clk_out),
        .clk_out_n (clk_out_n)
    );

    // R8: complement monitor on every cycle
    always @(negedge clk) begin
        if (mon_on && (clk_out_n !== ~clk_out)) comp_bad++;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] c, input logic e);
        @(negedge clk);
        rst = 1'b1;
        div_code = c;
        out_en = e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Wait until clk_out equals lvl at a negedge; lvl_ok reports success.
    task automatic wait_level(input logic lvl, input int cap, output bit lvl_ok);
        lvl_ok = 1'b0;
        for (int i = 0; i < cap; i++) begin
            if (clk_out === lvl) begin
                lvl_ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    // Count consecutive negedge samples at lvl, starting with the current one.
    task automatic run_len(input logic lvl, input int cap, output int n);
        n = 0;
        while (clk_out === lvl && n < cap) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_all();
        int  n;
        bit  ok;
        int  half;

        // R9: reset state
        do_reset(3'd1, 1'b0);
        mon_on = 1'b1;
        check("R9 reset true low", int'(clk_out), 0);
        check("R9 reset complement high", int'(clk_out_n), 1);

        // R1 / R2 / R3: sweep every code
        for (int c = 0; c < 8; c++) begin
            do_reset(3'(c), 1'b1);
            if (c >= 1 && c <= 5) begin
                half = 1 << (c - 1);
                wait_level(1'b1, 4, ok);
                check($sformatf("R5 start within one edge code %0d", c), int'(ok), 1);
                for (int p = 0; p < 3; p++) begin
                    run_len(1'b1, 100, n);
                    check($sformatf("R3 high run code %0d", c), n, half);
                    run_len(1'b0, 100, n);
                    check($sformatf("R3 low run code %0d", c), n, half);
                end
                run_len(1'b1, 100, n);
                check($sformatf("R1 period code %0d", c), n * 2, 1 << c);
            end else begin
                @(negedge clk);
                run_len(1'b0, 80, n);
                check($sformatf("R2 invalid code %0d parked", c), n, 80);
                check($sformatf("R2 invalid code %0d complement", c), int'(clk_out_n), 1);
            end
        end

        // R4 / R7: disable in mid high phase at ratio 16
        do_reset(3'd4, 1'b1);
        wait_level(1'b1, 4, ok);
        @(negedge clk);
        @(negedge clk);
        out_en = 1'b0;
        run_len(1'b1, 100, n);
        check("R4 high phase completes after disable", n, 6);
        run_len(1'b0, 60, n);
        check("R7 parked low after disable", n, 60);
        check("R7 complement high while parked", int'(clk_out_n), 1);

        // R5: enable from park gives a full high phase
        out_en = 1'b1;
        @(negedge clk);
        check("R5 high after one edge", int'(clk_out), 1);
        run_len(1'b1, 100, n);
        check("R5 full first high phase", n, 8);

        // R4: short enable drop in mid low phase has no effect
        wait_level(1'b0, 20, ok);
        out_en = 1'b0;
        @(negedge clk);
        out_en = 1'b1;
        run_len(1'b0, 100, n);
        check("R4 low phase unaffected by enable blip", n, 7);
        run_len(1'b1, 100, n);
        check("R4 next high phase full", n, 8);

        // R6: code change during high phase takes effect after the fall
        do_reset(3'd4, 1'b1);
        wait_level(1'b1, 4, ok);
        div_code = 3'd2;
        run_len(1'b1, 100, n);
        check("R6 running high keeps old ratio", n, 8);
        run_len(1'b0, 100, n);
        check("R6 low uses new ratio", n, 2);
        run_len(1'b1, 100, n);
        check("R6 high uses new ratio", n, 2);

        // R6: code change during low phase waits for the next fall
        wait_level(1'b0, 10, ok);
        div_code = 3'd5;
        run_len(1'b0, 100, n);
        check("R6 running low keeps old ratio", n, 2);
        run_len(1'b1, 100, n);
        check("R6 following high keeps old ratio", n, 2);
        run_len(1'b0, 100, n);
        check("R6 low after fall uses new ratio", n, 16);

        // R2: invalid code during running output
        do_reset(3'd3, 1'b1);
        wait_level(1'b1, 4, ok);
        div_code = 3'd7;
        run_len(1'b1, 100, n);
        check("R2 high completes before invalid park", n, 4);
        run_len(1'b0, 60, n);
        check("R2 parked after invalid code", n, 60);

        // R8: complement tracked on every cycle
        check("R8 complement mismatches", comp_bad, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        if (wd_hit) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule